// File: doc/BRIEF.md
# Banked Circular-Buffer Address Generator

This block produces memory addresses for indirect accesses that walk through circular buffers. It keeps sixteen pointer sets in each of two banks, a primary bank and a secondary bank. A pointer set has four fields: a current index, a signed step (the modifier), the start address of the buffer, and the buffer length. For each accepted access request the block returns the current index of the chosen set as the address. It then advances that index by the modifier. If the step carries the index past either end of the buffer, the index is folded back inside it. Software does nothing to wrap the pointer. A buffer may start at any address and have any length. There is no alignment rule and no power-of-two rule.

A single mode input picks which bank serves accesses. Software raises it when an interrupt handler is entered, which gives the handler its own pointer sets without saving the interrupted ones. Both banks keep their contents while the other bank is in use. A separate register port can write and read any field of any set in either bank directly, so loading and inspecting pointers does not depend on the mode input.

Access requests arrive on a valid/ready interface and addresses leave on a second valid/ready interface. The request side stalls (`acc_ready` low) when the address output holds an address that has not yet been taken, or when a register write is being made in the same cycle. An address on the output stays stable until `addr_ready` takes it.

Top module: `cbuf_agen`

## Requirements
- R1: After reset every field of every set in both banks reads as zero, `addr_valid` is low, and accesses are served from the primary bank.
- R2: The register port selects the bank with `reg_bank` (0 = primary, 1 = secondary), the set with `reg_set`, and the field with `reg_field`. The field codes are 0 = index, 1 = modifier, 2 = base, 3 = length. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the selected field combinationally.
- R3: Writing the base field (code 2) also loads the index of the same set with the written value.
- R4: An access is accepted at a rising edge where `acc_valid` and `acc_ready` are both high. From that edge on, `addr_out` carries the index the set held before the edge, with `addr_valid` high.
- R5: When the length L is not zero, an accepted access replaces the index with S = I + M, where M is read as a two's-complement value and the sum is not truncated. The result is S - L if S >= B + L, S + L if S < B, and S otherwise. Only the low 32 bits are kept.
- R6: When the length is zero, an accepted access replaces the index with I + M modulo 2^32, with no wrapping.
- R7: Accesses use the bank that `mode_sec` selected on the previous rising edge (0 = primary, 1 = secondary). A change of `mode_sec` therefore first affects an access accepted one edge later. Switching banks leaves the contents of both banks unchanged.
- R8: While `addr_valid` is high and `addr_ready` is low, `addr_out` and `addr_valid` hold their values and `acc_ready` is low.
- R9: `acc_ready` is low in any cycle where `reg_we` is high.
- R10: `addr_valid` rises only after an access has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sec | input | 1 | Bank select for accesses (1 = secondary) |
| reg_we | input | 1 | Register write enable |
| reg_bank | input | 1 | Bank addressed by the register port |
| reg_set | input | 4 | Set addressed by the register port |
| reg_field | input | 2 | Field code: 0 index, 1 modifier, 2 base, 3 length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected field, combinational |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be accepted |
| acc_set | input | 4 | Set used by the access |
| addr_valid | output | 1 | Generated address valid |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | 32 | Generated address |

## Verification
The assertions check on every cycle that a stalled address holds steady and blocks new requests, that register writes block requests, and that an output address only appears after an accepted request. They also check that, for any in-buffer index whose step is no larger than the length, the updated index stays within the buffer. Only the bench scenarios can show the exact wrapped values, including steps larger than the length, and the one-edge delay of the bank switch. The bench also shows that the index is loaded when the base is written, and that each bank keeps its contents while the other bank is in use.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX = 2'd0,
    FLD_MOD   = 2'd1,
    FLD_BASE  = 2'd2,
    FLD_LEN   = 2'd3
  } field_e;
endpackage

// File: rtl/cbuf_bank_sel.sv
module cbuf_bank_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sec,
  output logic bank_q
);
  // mode is registered: a change affects accesses one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= mode_sec;
  end
endmodule

// File: rtl/cbuf_wrap.sv
module cbuf_wrap #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] mod,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 3;

  logic signed [XW-1:0] s_sum, s_base, s_len, s_end, s_res;

  always_comb begin
    s_base = $signed({3'b000, base});
    s_len  = $signed({3'b000, len});
    s_sum  = $signed({3'b000, idx}) + $signed({{3{mod[AW-1]}}, mod});
    s_end  = s_base + s_len;
    if (len == '0)          s_res = s_sum;
    else if (s_sum >= s_end) s_res = s_sum - s_len;
    else if (s_sum < s_base) s_res = s_sum + s_len;
    else                     s_res = s_sum;
    nxt = s_res[AW-1:0];
  end
endmodule

// File: rtl/cbuf_regfile.sv
module cbuf_regfile
  import cbuf_agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 16,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [SW-1:0] wr_set,
  input  field_e        wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic          upd_bank,
  input  logic [SW-1:0] upd_set,
  input  logic [AW-1:0] upd_idx,
  input  logic          rd_bank,
  input  logic [SW-1:0] rd_set,
  input  field_e        rd_field,
  output logic [AW-1:0] rd_data,
  input  logic          acc_bank,
  input  logic [SW-1:0] acc_set,
  output logic [AW-1:0] acc_i,
  output logic [AW-1:0] acc_m,
  output logic [AW-1:0] acc_b,
  output logic [AW-1:0] acc_l
);
  logic [AW-1:0] rd_f   [2];
  logic [AW-1:0] ai     [2];
  logic [AW-1:0] am     [2];
  logic [AW-1:0] ab     [2];
  logic [AW-1:0] al     [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [AW-1:0] r_idx [NSETS];
    logic [AW-1:0] r_mod [NSETS];
    logic [AW-1:0] r_bas [NSETS];
    logic [AW-1:0] r_len [NSETS];
    logic wsel, usel;

    assign wsel = wr_en  && (wr_bank  == g[0]);
    assign usel = upd_en && (upd_bank == g[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < NSETS; s++) begin
          r_idx[s] <= '0;
          r_mod[s] <= '0;
          r_bas[s] <= '0;
          r_len[s] <= '0;
        end
      end else begin
        if (usel) r_idx[upd_set] <= upd_idx;
        if (wsel) begin
          unique case (wr_field)
            FLD_INDEX: r_idx[wr_set] <= wr_data;
            FLD_MOD:   r_mod[wr_set] <= wr_data;
            FLD_BASE: begin
              r_bas[wr_set] <= wr_data;
              r_idx[wr_set] <= wr_data;
            end
            FLD_LEN:   r_len[wr_set] <= wr_data;
          endcase
        end
      end
    end

    always_comb begin
      unique case (rd_field)
        FLD_INDEX: rd_f[g] = r_idx[rd_set];
        FLD_MOD:   rd_f[g] = r_mod[rd_set];
        FLD_BASE:  rd_f[g] = r_bas[rd_set];
        default:   rd_f[g] = r_len[rd_set];
      endcase
    end

    assign ai[g] = r_idx[acc_set];
    assign am[g] = r_mod[acc_set];
    assign ab[g] = r_bas[acc_set];
    assign al[g] = r_len[acc_set];
  end

  assign rd_data = rd_f[rd_bank];
  assign acc_i   = ai[acc_bank];
  assign acc_m   = am[acc_bank];
  assign acc_b   = ab[acc_bank];
  assign acc_l   = al[acc_bank];
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 16,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sec,
  input  logic          reg_we,
  input  logic          reg_bank,
  input  logic [SW-1:0] reg_set,
  input  logic [1:0]    reg_field,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [SW-1:0] acc_set,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out
);
  logic          bank_q;
  logic          fire;
  logic [AW-1:0] cur_i, cur_m, cur_b, cur_l, nxt_i;

  cbuf_bank_sel u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sec (mode_sec),
    .bank_q   (bank_q)
  );

  // R9: register writes and accesses never meet in one cycle
  assign acc_ready = (!addr_valid || addr_ready) && !reg_we;
  assign fire      = acc_valid && acc_ready;

  cbuf_regfile #(.AW(AW), .NSETS(NSETS)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_bank  (reg_bank),
    .wr_set   (reg_set),
    .wr_field (field_e'(reg_field)),
    .wr_data  (reg_wdata),
    .upd_en   (fire),
    .upd_bank (bank_q),
    .upd_set  (acc_set),
    .upd_idx  (nxt_i),
    .rd_bank  (reg_bank),
    .rd_set   (reg_set),
    .rd_field (field_e'(reg_field)),
    .rd_data  (reg_rdata),
    .acc_bank (bank_q),
    .acc_set  (acc_set),
    .acc_i    (cur_i),
    .acc_m    (cur_m),
    .acc_b    (cur_b),
    .acc_l    (cur_l)
  );

  cbuf_wrap #(.AW(AW)) u_wrap (
    .idx  (cur_i),
    .mod  (cur_m),
    .base (cur_b),
    .len  (cur_l),
    .nxt  (nxt_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else if (fire) begin
      addr_valid <= 1'b1;
      addr_out   <= cur_i;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cur_i,
  input logic [AW-1:0] cur_m,
  input logic [AW-1:0] cur_b,
  input logic [AW-1:0] cur_l,
  input logic [AW-1:0] nxt_i
);
  logic [AW:0]   endp;
  logic [AW-1:0] mag;
  logic          pre_ok;

  always_comb begin
    endp   = {1'b0, cur_b} + {1'b0, cur_l};
    mag    = cur_m[AW-1] ? (~cur_m + 1'b1) : cur_m;
    pre_ok = (cur_l != '0) && !endp[AW] && (cur_i >= cur_b) &&
             ({1'b0, cur_i} < endp) && (mag <= cur_l);
  end

  // R8
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !acc_ready);

  // R9
  a_r9_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !acc_ready);

  // R10
  a_r10_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(acc_valid && acc_ready));

  // R5
  a_r5_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ok |-> ((nxt_i >= cur_b) && ({1'b0, nxt_i} < endp)));
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_out   (addr_out),
  .cur_i      (cur_i),
  .cur_m      (cur_m),
  .cur_b      (cur_b),
  .cur_l      (cur_l),
  .nxt_i      (nxt_i)
);

// File: tb/cbuf_agen_tb.sv
`timescale 1ns/1ps
module cbuf_agen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_sec = 0;
  logic        reg_we = 0;
  logic        reg_bank = 0;
  logic [3:0]  reg_set = 0;
  logic [1:0]  reg_field = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 0;
  logic        acc_ready;
  logic [3:0]  acc_set = 0;
  logic        addr_valid;
  logic        addr_ready = 1;
  logic [31:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cbuf_agen u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(logic [31:0] i, logic [31:0] m,
                                             logic [31:0] b, logic [31:0] l);
    longint s, e;
    s = longint'(i) + longint'($signed(m));
    e = longint'(b) + longint'(l);
    if (l != 0) begin
      if (s >= e)               s = s - longint'(l);
      else if (s < longint'(b)) s = s + longint'(l);
    end
    return s[31:0];
  endfunction

  task automatic wr(input logic bank, input logic [3:0] set, input logic [1:0] f,
                    input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_bank = bank; reg_set = set; reg_field = f; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic bank, input logic [3:0] set, input logic [1:0] f,
                    output logic [31:0] d);
    reg_bank = bank; reg_set = set; reg_field = f;
    #1 d = reg_rdata;
  endtask

  task automatic load(input logic bank, input logic [3:0] set, input logic [31:0] b,
                      input logic [31:0] l, input logic [31:0] m);
    wr(bank, set, 2'd3, l);
    wr(bank, set, 2'd1, m);
    wr(bank, set, 2'd2, b);
  endtask

  // one access; address checked on the negedge after the accepting edge
  task automatic access(input logic [3:0] set, input string req, input logic [31:0] exp);
    @(negedge clk);
    acc_valid = 1; acc_set = set;
    @(negedge clk);
    acc_valid = 0;
    check({req, " valid"}, {31'd0, addr_valid}, 32'd1);
    check(req, addr_out, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    for (int f = 0; f < 4; f++) begin
      rd(1'b0, 4'd5, f[1:0], d); check("R1 prim", d, 0);
      rd(1'b1, 4'd9, f[1:0], d); check("R1 sec", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(1'b0, 4'd3, 2'd1, 32'hFFFF_FFFC);
    rd(1'b0, 4'd3, 2'd1, d); check("R2 modifier", d, 32'hFFFF_FFFC);
    wr(1'b1, 4'd3, 2'd3, 32'd77);
    rd(1'b1, 4'd3, 2'd3, d); check("R2 length sec", d, 32'd77);
    rd(1'b0, 4'd3, 2'd3, d); check("R2 length prim untouched", d, 0);
    wr(1'b0, 4'd3, 2'd0, 32'h55);
    rd(1'b0, 4'd3, 2'd0, d); check("R2 index", d, 32'h55);
    wr(1'b0, 4'd3, 2'd2, 32'h1000);
    rd(1'b0, 4'd3, 2'd2, d); check("R3 base", d, 32'h1000);
    rd(1'b0, 4'd3, 2'd0, d); check("R3 index loaded", d, 32'h1000);
  endtask

  task automatic t_wrap();
    load(1'b0, 4'd1, 32'd100, 32'd10, 32'd4);
    access(4'd1, "R4 first", 32'd100);
    access(4'd1, "R4 step", 32'd104);
    access(4'd1, "R5 step", 32'd108);
    access(4'd1, "R5 wrap high", 32'd102);
    load(1'b0, 4'd2, 32'd200, 32'd8, 32'hFFFF_FFFD);
    access(4'd2, "R5 neg first", 32'd200);
    access(4'd2, "R5 wrap low", 32'd205);
    access(4'd2, "R5 neg step", 32'd202);
  endtask

  task automatic t_linear();
    load(1'b0, 4'd4, 32'hFFFF_FFFE, 32'd0, 32'd3);
    access(4'd4, "R6 first", 32'hFFFF_FFFE);
    access(4'd4, "R6 modulo", 32'h0000_0001);
  endtask

  task automatic t_bank();
    logic [31:0] d;
    load(1'b0, 4'd7, 32'd10, 32'd0, 32'd1);
    load(1'b1, 4'd7, 32'd500, 32'd0, 32'd2);
    @(negedge clk);
    mode_sec = 1; acc_valid = 1; acc_set = 4'd7;
    @(negedge clk);
    check("R7 same-edge still primary", addr_out, 32'd10);
    @(negedge clk);
    check("R7 next edge secondary", addr_out, 32'd500);
    acc_valid = 0;
    mode_sec = 0;
    rd(1'b0, 4'd7, 2'd0, d); check("R7 primary kept", d, 32'd11);
    rd(1'b1, 4'd7, 2'd0, d); check("R7 secondary kept", d, 32'd502);
    @(negedge clk);
    access(4'd7, "R7 back to primary", 32'd11);
  endtask

  task automatic t_stall();
    load(1'b0, 4'd8, 32'd40, 32'd0, 32'd1);
    @(negedge clk);
    addr_ready = 0; acc_valid = 1; acc_set = 4'd8;
    @(negedge clk);
    check("R8 first out", addr_out, 32'd40);
    check("R8 ready low", {31'd0, acc_ready}, 0);
    @(negedge clk);
    check("R8 held", addr_out, 32'd40);
    check("R8 still valid", {31'd0, addr_valid}, 1);
    addr_ready = 1;
    #1 check("R8 ready returns", {31'd0, acc_ready}, 1);
    @(negedge clk);
    acc_valid = 0;
    check("R8 second out", addr_out, 32'd41);
    reg_we = 1; reg_bank = 1; reg_set = 4'd15; reg_field = 2'd1; reg_wdata = 0;
    #1 check("R9 write blocks", {31'd0, acc_ready}, 0);
    @(negedge clk);
    reg_we = 0;
    check("R10 valid drops", {31'd0, addr_valid}, 0);
  endtask

  task automatic t_random();
    logic [31:0] b, l, m, i;
    for (int k = 0; k < 150; k++) begin
      b = $urandom;
      l = (k % 10 == 0) ? 32'd0 : ($urandom % 1000) + 1;
      case (k % 3)
        0: m = $urandom % (l + 1);
        1: m = -($urandom % (2 * l + 3));
        default: m = ($urandom % (3 * l + 3));
      endcase
      load(1'b0, 4'(k % 16), b, l, m);
      i = b;
      for (int a = 0; a < 6; a++) begin
        access(4'(k % 16), "R5 random", i);
        i = model_next(i, m, b, l);
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_wrap();
        t_linear();
        t_bank();
        t_stall();
        t_random();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule